// File: doc/BRIEF.md
# Flash Bus Write and Error Sequencer

This block sits between a simplified AHB-style slave port and the port of a flash array. It takes one transfer at a time. For an allowed write it places the address, the write data and a write strobe on the array side. For an allowed read it raises a read strobe. In both cases it then counts a programmable number of wait states before it ends the bus transfer. For a read, it hands back the data the array returned.

Each transfer is checked before anything reaches the array. The checks are a per-master read permission vector, a per-master write permission vector, and an external input that can lock out all writes. A refused transfer never touches the array and ends with the standard two-cycle ERROR response. An array that flags an error on the final cycle of an access gets the same ERROR response.

Top module: `flash_wr_seq`

## Requirements
- R1: During and right after synchronous reset, `bus_ready_out` is 1, `bus_resp` is 0, and both `arr_we` and `arr_re` are 0. This also holds when reset is applied in the middle of a transfer.
- R2: A request is accepted on the clock edge where `bus_req` is high in the idle state. On the next edge, the array access is launched: `arr_addr` takes the accepted address, `arr_wdata` takes the `bus_wdata` present in the cycle after acceptance, and `arr_we` (write, `bus_write`=1) or `arr_re` (read) is raised.
- R3: `bus_ready_out` goes low after acceptance. Once launched, the strobe, address and data stay unchanged for `cfg_wait`+1 cycles. `bus_ready_out` returns high on the cycle after that: with `cfg_wait`=0 it is high in the cycle right after the launch cycle.
- R4: The strobe, address and write data return to 0 on the edge that ends the transfer.
- R5: An error response is `bus_resp`=1 with `bus_ready_out`=0 for one cycle. After that, both are 1 until `bus_ready_in` is sampled high. On that edge `bus_resp` drops to 0 and `bus_ready_out` stays 1.
- R6: A write from master `bus_mid` whose bit in `cfg_wr_perm` is 0 is refused. A read from a master whose bit in `cfg_rd_perm` is 0 is refused. A refused access gives the error response in the two cycles after launch would have happened, and no strobe is raised.
- R7: When `arr_write_ok` is 0, every write is refused without a strobe, in the same way as R6. Reads proceed normally.
- R8: When `arr_err` is high on the final wait cycle of an access, read or write, the error response starts on the cycle where ready would otherwise have returned.
- R9: A successful read presents the `arr_rdata` value from the final wait cycle on `bus_rdata` when `bus_ready_out` returns high.
- R10: `cfg_wait` is sampled only at launch. Changing it during the wait has no effect on the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request (address phase valid) |
| bus_addr | input | AW | Transfer address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_mid | input | MIDW | Requesting master number |
| bus_wdata | input | DW | Write data, valid in the cycle after acceptance |
| bus_ready_in | input | 1 | Bus ready, ends the held error response |
| bus_ready_out | output | 1 | Transfer complete / slave ready |
| bus_resp | output | 1 | Error response bit |
| bus_rdata | output | DW | Read data |
| cfg_wait | input | WSW | Wait-state count |
| cfg_rd_perm | input | 2**MIDW | Read permission, one bit per master |
| cfg_wr_perm | input | 2**MIDW | Write permission, one bit per master |
| arr_write_ok | input | 1 | Array write enable from outside |
| arr_addr | output | AW | Array address |
| arr_wdata | output | DW | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_re | output | 1 | Array read strobe |
| arr_rdata | input | DW | Array read data |
| arr_err | input | 1 | Array error flag |

## Verification
Cycles are counted from the acceptance edge, and every sample is taken on the falling edge. Ready drops in cycle 1 and a launched strobe shows in cycle 2. For wait count N, completion shows in cycle N+3, an array error shows in cycle N+3 with ready low, and a refusal shows in cycle 2 with ready low. The bench records the cycle at which each event first appears and compares it with these figures. It then holds `bus_ready_in` low for two more cycles to confirm the error is held, and raises it to confirm the release on the following cycle.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DATA = 3'd1,
    S_WAIT = 3'd2,
    S_ERR1 = 3'd3,
    S_ERR2 = 3'd4
  } seq_state_t;
endpackage

// File: rtl/flseq_access_gate.sv
module flseq_access_gate #(
  parameter int MIDW = 2,
  localparam int NM = 1 << MIDW
) (
  input  logic            is_write,
  input  logic [MIDW-1:0] mid,
  input  logic [NM-1:0]   rd_perm,
  input  logic [NM-1:0]   wr_perm,
  input  logic            write_ok,
  output logic            refuse
);
  logic [NM-1:0] sel;
  logic          rd_allow;
  logic          wr_allow;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_dec
      assign sel[g] = (mid == MIDW'(g));
    end
  endgenerate

  assign rd_allow = |(sel & rd_perm);
  assign wr_allow = (|(sel & wr_perm)) & write_ok;
  assign refuse   = is_write ? !wr_allow : !rd_allow;
endmodule

// File: rtl/flseq_wait_ctr.sv
module flseq_wait_ctr #(
  parameter int WSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [WSW-1:0] load_val,
  output logic           zero
);
  logic [WSW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq #(
  parameter int AW   = 24,
  parameter int DW   = 64,
  parameter int MIDW = 2,
  parameter int WSW  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_write,
  input  logic [MIDW-1:0]      bus_mid,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_ready_in,
  output logic                 bus_ready_out,
  output logic                 bus_resp,
  output logic [DW-1:0]        bus_rdata,
  input  logic [WSW-1:0]       cfg_wait,
  input  logic [(1<<MIDW)-1:0] cfg_rd_perm,
  input  logic [(1<<MIDW)-1:0] cfg_wr_perm,
  input  logic                 arr_write_ok,
  output logic [AW-1:0]        arr_addr,
  output logic [DW-1:0]        arr_wdata,
  output logic                 arr_we,
  output logic                 arr_re,
  input  logic [DW-1:0]        arr_rdata,
  input  logic                 arr_err
);
  import flseq_pkg::*;

  seq_state_t      st;
  logic [AW-1:0]   a_addr;
  logic            a_write;
  logic [MIDW-1:0] a_mid;
  logic            refuse;
  logic            cnt_zero;
  logic            launch;

  flseq_access_gate #(.MIDW(MIDW)) u_gate (
    .is_write (a_write),
    .mid      (a_mid),
    .rd_perm  (cfg_rd_perm),
    .wr_perm  (cfg_wr_perm),
    .write_ok (arr_write_ok),
    .refuse   (refuse)
  );

  assign launch = (st == S_DATA) && !refuse;

  flseq_wait_ctr #(.WSW(WSW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .load_val (cfg_wait),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      bus_ready_out <= 1'b1;
      bus_resp      <= 1'b0;
      bus_rdata     <= '0;
      arr_addr      <= '0;
      arr_wdata     <= '0;
      arr_we        <= 1'b0;
      arr_re        <= 1'b0;
      a_addr        <= '0;
      a_write       <= 1'b0;
      a_mid         <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (bus_req) begin
            a_addr        <= bus_addr;
            a_write       <= bus_write;
            a_mid         <= bus_mid;
            bus_ready_out <= 1'b0;
            st            <= S_DATA;
          end
        end
        S_DATA: begin
          if (refuse) begin
            bus_resp <= 1'b1;
            st       <= S_ERR1;
          end else begin
            arr_addr  <= a_addr;
            arr_wdata <= a_write ? bus_wdata : '0;
            arr_we    <= a_write;
            arr_re    <= !a_write;
            st        <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt_zero) begin
            arr_addr  <= '0;
            arr_wdata <= '0;
            arr_we    <= 1'b0;
            arr_re    <= 1'b0;
            if (arr_err) begin
              bus_resp <= 1'b1;
              st       <= S_ERR1;
            end else begin
              bus_ready_out <= 1'b1;
              if (!a_write) bus_rdata <= arr_rdata;
              st <= S_IDLE;
            end
          end
        end
        S_ERR1: begin
          bus_ready_out <= 1'b1;
          st            <= S_ERR2;
        end
        S_ERR2: begin
          if (bus_ready_in) begin
            bus_resp <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flseq_checker.sv
module flseq_checker #(
  parameter int AW = 24,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ready_out,
  input logic          bus_resp,
  input logic          bus_ready_in,
  input logic [AW-1:0] arr_addr,
  input logic [DW-1:0] arr_wdata,
  input logic          arr_we,
  input logic          arr_re
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (bus_ready_out && !bus_resp && !arr_we && !arr_re));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(arr_we && arr_re));

  a_r3_busy_while_strobe: assert property (@(posedge clk) disable iff (rst)
    (arr_we || arr_re) |-> !bus_ready_out);

  a_r3_hold_launch: assert property (@(posedge clk) disable iff (rst)
    ((arr_we && $past(arr_we)) || (arr_re && $past(arr_re)))
      |-> ($stable(arr_addr) && $stable(arr_wdata)));

  a_r5_err_first_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_resp) |-> !bus_ready_out);

  a_r5_err_held: assert property (@(posedge clk) disable iff (rst)
    (bus_resp && bus_ready_out && !bus_ready_in) |=> (bus_resp && bus_ready_out));

  a_r6_no_strobe_in_err: assert property (@(posedge clk) disable iff (rst)
    bus_resp |-> (!arr_we && !arr_re));
endmodule

bind flash_wr_seq flseq_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_ready_out (bus_ready_out),
  .bus_resp      (bus_resp),
  .bus_ready_in  (bus_ready_in),
  .arr_addr      (arr_addr),
  .arr_wdata     (arr_wdata),
  .arr_we        (arr_we),
  .arr_re        (arr_re)
);

// File: tb/sim_flash_wr_seq.sv
module sim_flash_wr_seq;
  localparam int AW = 24;
  localparam int DW = 64;
  localparam int MIDW = 2;
  localparam int WSW = 3;
  localparam int NV = 11;

  logic clk = 0;
  logic rst = 1;
  logic bus_req = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_write = 0;
  logic [MIDW-1:0] bus_mid = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ready_in = 0;
  logic bus_ready_out, bus_resp;
  logic [DW-1:0] bus_rdata;
  logic [WSW-1:0] cfg_wait = '0;
  logic [3:0] cfg_rd_perm = 4'hF;
  logic [3:0] cfg_wr_perm = 4'hF;
  logic arr_write_ok = 1;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic arr_we, arr_re;
  logic [DW-1:0] arr_rdata = '0;
  logic arr_err = 0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_wr_seq #(.AW(AW), .DW(DW), .MIDW(MIDW), .WSW(WSW)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_mid(bus_mid), .bus_wdata(bus_wdata),
    .bus_ready_in(bus_ready_in), .bus_ready_out(bus_ready_out),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata), .cfg_wait(cfg_wait),
    .cfg_rd_perm(cfg_rd_perm), .cfg_wr_perm(cfg_wr_perm),
    .arr_write_ok(arr_write_ok), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_we(arr_we), .arr_re(arr_re), .arr_rdata(arr_rdata), .arr_err(arr_err)
  );

  // {write, mid[1:0], wait[2:0], rd_perm[3:0], wr_perm[3:0], write_ok, arr_err}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 2'd0, 3'd0, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b1, 2'd1, 3'd3, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b1, 2'd3, 3'd7, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b0, 2'd2, 3'd2, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b0, 2'd0, 3'd0, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b1, 2'd2, 3'd1, 4'hF, 4'hB, 1'b1, 1'b0},
    {1'b0, 2'd1, 3'd4, 4'hD, 4'hF, 1'b1, 1'b0},
    {1'b1, 2'd0, 3'd2, 4'hF, 4'hF, 1'b0, 1'b0},
    {1'b0, 2'd3, 3'd1, 4'hF, 4'hF, 1'b0, 1'b0},
    {1'b1, 2'd1, 3'd2, 4'hF, 4'hF, 1'b1, 1'b1},
    {1'b0, 2'd2, 3'd0, 4'hF, 4'hF, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] v, input int i);
    logic w; logic [1:0] mid; logic [2:0] ws; logic [3:0] rdp, wrp; logic wok, aerr;
    logic refused, exp_err;
    logic [AW-1:0] adr; logic [DW-1:0] dat, rd;
    int k_launch, scount, k_resp, k_done;
    logic [AW-1:0] la; logic [DW-1:0] ld; bit kind_ok;
    {w, mid, ws, rdp, wrp, wok, aerr} = v;
    refused = w ? (!wrp[mid] || !wok) : !rdp[mid];
    exp_err = refused || aerr;
    adr = AW'(24'hA00000 + i * 24'h111);
    dat = {32'hC0DE0000 + 32'(i), 32'h5A5A0000 + 32'(i)};
    rd  = 64'hFEED000000000000 | 64'(i);
    @(negedge clk);
    cfg_wait = ws; cfg_rd_perm = rdp; cfg_wr_perm = wrp; arr_write_ok = wok;
    arr_err = aerr; arr_rdata = rd;
    bus_req = 1; bus_addr = adr; bus_write = w; bus_mid = mid; bus_wdata = '0;
    @(posedge clk); @(negedge clk);
    bus_req = 0; bus_addr = '0; bus_wdata = dat;
    chk(bus_ready_out == 0, "R3 ready low after accept", 64'(bus_ready_out), 0);
    k_launch = 0; scount = 0; k_resp = 0; k_done = 0; la = '0; ld = '0; kind_ok = 1;
    for (int k = 2; k <= 24 && k_done == 0; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 2) cfg_wait = ~ws; // R10: change after launch
      if (arr_we || arr_re) begin
        scount++;
        if (k_launch == 0) begin
          k_launch = k; la = arr_addr; ld = arr_wdata;
          kind_ok = (arr_we == w) && (arr_re == !w);
        end
      end
      if (bus_resp && k_resp == 0) begin
        k_resp = k;
        chk(!bus_ready_out, "R5 first err cycle ready low", 64'(bus_ready_out), 0);
      end
      if (bus_ready_out) k_done = k;
    end
    chk(!arr_we && !arr_re, "R4 strobes cleared at end", 64'({arr_we, arr_re}), 0);
    if (refused) begin
      chk(scount == 0, (w && wrp[mid] && !wok) ? "R7 no strobe" : "R6 no strobe", 64'(scount), 0);
      chk(k_resp == 2, "R6 err cycle", 64'(k_resp), 2);
      chk(k_done == 3, "R6 ready cycle", 64'(k_done), 3);
    end else begin
      chk(k_launch == 2, "R2 launch cycle", 64'(k_launch), 2);
      chk(la == adr, "R2 array address", 64'(la), 64'(adr));
      if (w) chk(ld == dat, "R2 array wdata", ld, dat);
      chk(kind_ok, "R2 strobe kind", 64'(kind_ok), 1);
      chk(scount == int'(ws) + 1, "R3/R10 strobe length", 64'(scount), 64'(ws) + 1);
      if (!w && !wok) chk(scount == int'(ws) + 1, "R7 read unaffected", 64'(scount), 64'(ws) + 1);
      if (aerr) begin
        chk(k_resp == int'(ws) + 3, "R8 err cycle", 64'(k_resp), 64'(ws) + 3);
        chk(k_done == int'(ws) + 4, "R8 ready cycle", 64'(k_done), 64'(ws) + 4);
      end else begin
        chk(k_done == int'(ws) + 3, "R3/R10 completion cycle", 64'(k_done), 64'(ws) + 3);
        chk(k_resp == 0, "R3 no error", 64'(k_resp), 0);
        if (!w) chk(bus_rdata == rd, "R9 read data", bus_rdata, rd);
      end
    end
    if (exp_err) begin
      for (int j = 0; j < 2; j++) begin
        @(posedge clk); @(negedge clk);
        chk(bus_resp && bus_ready_out, "R5 error held", 64'({bus_resp, bus_ready_out}), 3);
      end
      bus_ready_in = 1;
      @(posedge clk); @(negedge clk);
      bus_ready_in = 0;
      chk(!bus_resp && bus_ready_out, "R5 error released", 64'({bus_resp, bus_ready_out}), 1);
    end
    arr_err = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_ready_out && !bus_resp && !arr_we && !arr_re, "R1 reset state",
        64'({bus_ready_out, bus_resp, arr_we, arr_re}), 64'h8);
    rst = 0;
    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
    // R1: reset in the middle of a long write
    @(negedge clk);
    cfg_wait = 3'd7; cfg_rd_perm = 4'hF; cfg_wr_perm = 4'hF; arr_write_ok = 1;
    bus_req = 1; bus_write = 1; bus_addr = 24'h123456; bus_mid = 2'd1;
    @(posedge clk); @(negedge clk);
    bus_req = 0; bus_wdata = 64'h0123456789ABCDEF;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk(arr_we, "R1 precondition strobe up", 64'(arr_we), 1);
    rst = 1;
    @(posedge clk); @(negedge clk);
    chk(bus_ready_out && !bus_resp && !arr_we && !arr_re, "R1 mid-transfer reset",
        64'({bus_ready_out, bus_resp, arr_we, arr_re}), 64'h8);
    rst = 0;
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule